// File: doc/BRIEF.md
# Logical-Operation Status Flag Unit

This block executes 32-bit bitwise logical operations (AND, OR, XOR) for a DSP datapath. It also keeps a small status register with five flags (DC, N, Z, V, GT) and a 3-bit condition-select field. The condition-select field decides what the DC flag means after a logical operation. Software loads it through a dedicated write port.

An instruction can be unconditional or conditional. An unconditional operation writes its result and refreshes all five flags. A conditional operation runs only when the current DC flag matches the requested polarity. When it runs, it writes its result, but it never changes any flag. The result, the result-write strobe and the flags are all registered, so they appear one clock after the operation is presented.

Top module: `dsp_logic_flag_unit`

## Requirements
- R1: While rst_ni is low, all flags, cs_o, result_o and result_we_o are zero.
- R2: The operation code op_sel_i works as follows: 00 = AND, 01 = OR, 10 = XOR, and 11 gives an all-zero result. An executed operation drives result_o and pulses result_we_o high for one cycle, one clock after op_valid_i is sampled.
- R3: When cs_o is 001 (negative mode), an unconditional operation loads bit 31 of its result into DC.
- R4: When cs_o is 010 (zero mode), an unconditional operation sets DC if the 32-bit result is zero, and clears DC otherwise.
- R5: When cs_o is 000, 011, 100, 101, 110 or 111, an unconditional operation clears DC.
- R6: After every unconditional operation, N equals result bit 31 and Z equals (result == 0), while V and GT are cleared, whatever cs_o holds.
- R7: A conditional operation (cond_en_i = 1) whose condition holds writes its result but leaves DC, N, Z, V and GT unchanged. The condition holds when DC equals cond_pol_i.
- R8: A conditional operation whose condition fails gives no result_we_o pulse, keeps result_o unchanged and leaves all flags unchanged.
- R9: When cs_we_i is high, cs_o takes cs_wdata_i on the next clock. In that same cycle no flag is updated, even if an unconditional operation is presented.
- R10: When neither op_valid_i nor cs_we_i is high, the flags, cs_o and result_o stay unchanged and result_we_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation presented this cycle |
| op_sel_i | input | 2 | Logical operation code |
| cond_en_i | input | 1 | 1 = conditional operation |
| cond_pol_i | input | 1 | DC value that lets a conditional operation run |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second operand |
| cs_we_i | input | 1 | Condition-select write enable |
| cs_wdata_i | input | 3 | New condition-select value |
| result_o | output | 32 | Last written result |
| result_we_o | output | 1 | Result-write strobe |
| dc_o | output | 1 | DC flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| gt_o | output | 1 | Greater-than flag |
| cs_o | output | 3 | Condition-select field |

## Verification
The result, the strobe, the flags and the condition-select field each pass through exactly one register. So each one is due on the first rising edge after its stimulus is presented. The bench drives inputs on the falling edge and samples every output on the following falling edge, half a period after the capturing edge. It removes the stimulus before the next rising edge, so no check sees a second update. A conditional operation is always checked against the DC value that the previous operation left behind.

// File: rtl/dsp_lfu_pkg.sv
package dsp_lfu_pkg;
  localparam int DATA_W = 32;
  localparam int CS_W   = 3;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_XOR  = 2'b10,
    OP_NONE = 2'b11
  } op_e;

  typedef enum logic [CS_W-1:0] {
    CS_CARRY = 3'b000,
    CS_NEG   = 3'b001,
    CS_ZERO  = 3'b010,
    CS_OVF   = 3'b011,
    CS_GT    = 3'b100,
    CS_GE    = 3'b101,
    CS_RSV6  = 3'b110,
    CS_RSV7  = 3'b111
  } cs_e;

  typedef struct packed {
    logic dc;
    logic n;
    logic z;
    logic v;
    logic gt;
  } flags_t;
endpackage

// File: rtl/dsp_lfu_logic.sv
module dsp_lfu_logic
  import dsp_lfu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (op_e'(op_i))
        OP_AND:  res_o[i] = a_i[i] & b_i[i];
        OP_OR:   res_o[i] = a_i[i] | b_i[i];
        OP_XOR:  res_o[i] = a_i[i] ^ b_i[i];
        default: res_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dsp_lfu_flag_gen.sv
module dsp_lfu_flag_gen
  import dsp_lfu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0]    res_i,
  input  logic [CS_W-1:0] cs_i,
  output flags_t          flags_o
);
  logic sign, zero;

  assign sign = res_i[W-1];
  assign zero = ~|res_i;

  always_comb begin
    flags_o.n  = sign;
    flags_o.z  = zero;
    // logical ops never overflow nor compare
    flags_o.v  = 1'b0;
    flags_o.gt = 1'b0;
    unique case (cs_e'(cs_i))
      CS_NEG:  flags_o.dc = sign;
      CS_ZERO: flags_o.dc = zero;
      default: flags_o.dc = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsp_lfu_cond.sv
module dsp_lfu_cond (
  input  logic valid_i,
  input  logic cond_en_i,
  input  logic cond_pol_i,
  input  logic cs_we_i,
  input  logic dc_i,
  output logic exec_o,
  output logic flag_upd_o
);
  assign exec_o     = valid_i & (~cond_en_i | (dc_i == cond_pol_i));
  // CS write wins over flag refresh
  assign flag_upd_o = valid_i & ~cond_en_i & ~cs_we_i;
endmodule

// File: rtl/dsp_lfu_status.sv
module dsp_lfu_status
  import dsp_lfu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exec_i,
  input  logic            flag_upd_i,
  input  logic [W-1:0]    res_i,
  input  flags_t          flags_i,
  input  logic            cs_we_i,
  input  logic [CS_W-1:0] cs_wdata_i,
  output logic [W-1:0]    res_o,
  output logic            res_we_o,
  output flags_t          flags_o,
  output logic [CS_W-1:0] cs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o    <= '0;
      res_we_o <= 1'b0;
      flags_o  <= '0;
      cs_o     <= '0;
    end else begin
      res_we_o <= exec_i;
      if (exec_i) res_o <= res_i;
      if (cs_we_i) cs_o <= cs_wdata_i;
      else if (flag_upd_i) flags_o <= flags_i;
    end
  end
endmodule

// File: rtl/dsp_logic_flag_unit.sv
module dsp_logic_flag_unit
  import dsp_lfu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [1:0]      op_sel_i,
  input  logic            cond_en_i,
  input  logic            cond_pol_i,
  input  logic [W-1:0]    src_a_i,
  input  logic [W-1:0]    src_b_i,
  input  logic            cs_we_i,
  input  logic [CS_W-1:0] cs_wdata_i,
  output logic [W-1:0]    result_o,
  output logic            result_we_o,
  output logic            dc_o,
  output logic            n_o,
  output logic            z_o,
  output logic            v_o,
  output logic            gt_o,
  output logic [CS_W-1:0] cs_o
);
  logic [W-1:0] res_d;
  flags_t       flags_d, flags_q;
  logic         exec, flag_upd;

  dsp_lfu_logic #(.W(W)) u_logic (
    .op_i (op_sel_i),
    .a_i  (src_a_i),
    .b_i  (src_b_i),
    .res_o(res_d)
  );

  dsp_lfu_flag_gen #(.W(W)) u_flag (
    .res_i  (res_d),
    .cs_i   (cs_o),
    .flags_o(flags_d)
  );

  dsp_lfu_cond u_cond (
    .valid_i   (op_valid_i),
    .cond_en_i (cond_en_i),
    .cond_pol_i(cond_pol_i),
    .cs_we_i   (cs_we_i),
    .dc_i      (flags_q.dc),
    .exec_o    (exec),
    .flag_upd_o(flag_upd)
  );

  dsp_lfu_status #(.W(W)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exec_i    (exec),
    .flag_upd_i(flag_upd),
    .res_i     (res_d),
    .flags_i   (flags_d),
    .cs_we_i   (cs_we_i),
    .cs_wdata_i(cs_wdata_i),
    .res_o     (result_o),
    .res_we_o  (result_we_o),
    .flags_o   (flags_q),
    .cs_o      (cs_o)
  );

  assign dc_o = flags_q.dc;
  assign n_o  = flags_q.n;
  assign z_o  = flags_q.z;
  assign v_o  = flags_q.v;
  assign gt_o = flags_q.gt;
endmodule

// File: rtl/dsp_lfu_chk.sv
module dsp_lfu_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         op_valid_i,
  input logic         cond_en_i,
  input logic         cond_pol_i,
  input logic         cs_we_i,
  input logic [2:0]   cs_wdata_i,
  input logic [W-1:0] result_o,
  input logic         result_we_o,
  input logic         dc_o,
  input logic         n_o,
  input logic         z_o,
  input logic         v_o,
  input logic         gt_o,
  input logic [2:0]   cs_o
);
  logic [4:0] fl;
  assign fl = {dc_o, n_o, z_o, v_o, gt_o};

  // R2
  exec_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !cond_en_i) |=> result_we_o);

  // R3
  neg_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !cond_en_i && !cs_we_i && cs_o == 3'b001) |=> dc_o == result_o[W-1]);

  // R4
  zero_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !cond_en_i && !cs_we_i && cs_o == 3'b010) |=> dc_o == (result_o == '0));

  // R5
  dc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !cond_en_i && !cs_we_i && cs_o != 3'b001 && cs_o != 3'b010) |=> !dc_o);

  // R6
  side_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !cond_en_i && !cs_we_i) |=>
      (n_o == result_o[W-1] && z_o == (result_o == '0) && !v_o && !gt_o));

  // R7
  cond_keep_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cond_en_i) |=> $stable(fl));

  // R8
  cond_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cond_en_i && dc_o != cond_pol_i) |=> (!result_we_o && $stable(result_o)));

  // R9
  cs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_we_i |=> (cs_o == $past(cs_wdata_i) && $stable(fl)));

  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !cs_we_i) |=> (!result_we_o && $stable(result_o) && $stable(fl) && $stable(cs_o)));
endmodule

bind dsp_logic_flag_unit dsp_lfu_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .cond_en_i  (cond_en_i),
  .cond_pol_i (cond_pol_i),
  .cs_we_i    (cs_we_i),
  .cs_wdata_i (cs_wdata_i),
  .result_o   (result_o),
  .result_we_o(result_we_o),
  .dc_o       (dc_o),
  .n_o        (n_o),
  .z_o        (z_o),
  .v_o        (v_o),
  .gt_o       (gt_o),
  .cs_o       (cs_o)
);

// File: tb/tb_dsp_logic_flag_unit.sv
module tb_dsp_logic_flag_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [1:0]  op_sel_i = 2'b00;
  logic        cond_en_i = 1'b0;
  logic        cond_pol_i = 1'b0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic        cs_we_i = 1'b0;
  logic [2:0]  cs_wdata_i = '0;
  logic [31:0] result_o;
  logic        result_we_o, dc_o, n_o, z_o, v_o, gt_o;
  logic [2:0]  cs_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dsp_logic_flag_unit dut (.*);

  // {op, cs, a, b, expected result}
  localparam logic [100:0] VEC [10] = '{
    {2'b00, 3'b000, 32'hFFFF0000, 32'h0F0F0F0F, 32'h0F0F0000},
    {2'b01, 3'b001, 32'h80000000, 32'h00000001, 32'h80000001},
    {2'b10, 3'b010, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'h00000000},
    {2'b00, 3'b010, 32'h12345678, 32'h87654321, 32'h02244220},
    {2'b01, 3'b011, 32'h00000000, 32'h00000000, 32'h00000000},
    {2'b10, 3'b100, 32'hFFFFFFFF, 32'h0000FFFF, 32'hFFFF0000},
    {2'b00, 3'b101, 32'h80000000, 32'h80000000, 32'h80000000},
    {2'b11, 3'b110, 32'hDEADBEEF, 32'h12345678, 32'h00000000},
    {2'b10, 3'b111, 32'h7FFFFFFF, 32'h00000000, 32'h7FFFFFFF},
    {2'b01, 3'b001, 32'h00000001, 32'h00000000, 32'h00000001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_dc(input logic [2:0] cs, input logic [31:0] r);
    if (cs == 3'b001) return r[31];
    if (cs == 3'b010) return r == 32'h0;
    return 1'b0;
  endfunction

  task automatic write_cs(input logic [2:0] v);
    @(negedge clk_i);
    cs_we_i = 1'b1; cs_wdata_i = v;
    @(negedge clk_i);
    cs_we_i = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic ce, input logic pol);
    @(negedge clk_i);
    op_valid_i = 1'b1; op_sel_i = op; src_a_i = a; src_b_i = b;
    cond_en_i = ce; cond_pol_i = pol;
    @(negedge clk_i);
    op_valid_i = 1'b0; cond_en_i = 1'b0;
  endtask

  function automatic logic [31:0] flags();
    return {27'd0, dc_o, n_o, z_o, v_o, gt_o};
  endfunction

  initial begin
    logic [31:0] held;
    logic [31:0] fl_hold;
    #3;
    // R1
    chk("R1 reset flags", flags(), 32'd0);
    chk("R1 reset result", result_o, 32'd0);
    chk("R1 reset cs/we", {28'd0, cs_o, result_we_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;

    foreach (VEC[k]) begin
      logic [1:0]  op  = VEC[k][100:99];
      logic [2:0]  cs  = VEC[k][98:96];
      logic [31:0] a   = VEC[k][95:64];
      logic [31:0] b   = VEC[k][63:32];
      logic [31:0] exp = VEC[k][31:0];
      write_cs(cs);
      chk("R9 cs load", {29'd0, cs_o}, {29'd0, cs});
      @(negedge clk_i);
      op_valid_i = 1'b1; op_sel_i = op; src_a_i = a; src_b_i = b; cond_en_i = 1'b0;
      @(negedge clk_i);
      op_valid_i = 1'b0;
      chk("R2 result", result_o, exp);
      chk("R2 strobe", {31'd0, result_we_o}, 32'd1);
      chk("R3/R4/R5 dc", {31'd0, dc_o}, {31'd0, exp_dc(cs, exp)});
      chk("R6 n z v gt", {28'd0, n_o, z_o, v_o, gt_o},
          {28'd0, exp[31], exp == 32'h0, 1'b0, 1'b0});
      @(negedge clk_i);
      chk("R2 strobe one cycle", {31'd0, result_we_o}, 32'd0);
    end

    // set DC=1 in negative mode
    write_cs(3'b001);
    run_op(2'b01, 32'h80000000, 32'h0, 1'b0, 1'b0);
    chk("R3 dc set", {31'd0, dc_o}, 32'd1);
    fl_hold = flags();

    // R7: condition DC==1 holds, zero result must not touch Z/DC
    run_op(2'b00, 32'h0, 32'hFFFFFFFF, 1'b1, 1'b1);
    chk("R7 result written", result_o, 32'h0);
    chk("R7 strobe", {31'd0, result_we_o}, 32'd1);
    chk("R7 flags kept", flags(), fl_hold);

    // R8: condition DC==0 fails
    held = result_o;
    run_op(2'b01, 32'h1234, 32'h1, 1'b1, 1'b0);
    chk("R8 no strobe", {31'd0, result_we_o}, 32'd0);
    chk("R8 result held", result_o, held);
    chk("R8 flags kept", flags(), fl_hold);

    // R9: CS write blocks flag update of concurrent op
    @(negedge clk_i);
    op_valid_i = 1'b1; op_sel_i = 2'b10; src_a_i = 32'h5; src_b_i = 32'h5; cond_en_i = 1'b0;
    cs_we_i = 1'b1; cs_wdata_i = 3'b010;
    @(negedge clk_i);
    op_valid_i = 1'b0; cs_we_i = 1'b0;
    chk("R9 cs written", {29'd0, cs_o}, 32'd2);
    chk("R9 flags blocked", flags(), fl_hold);
    chk("R9 result still written", result_o, 32'h0);

    // R10: idle with changing operands
    held = result_o;
    @(negedge clk_i);
    src_a_i = 32'hFFFFFFFF; src_b_i = 32'h1; cs_wdata_i = 3'b111;
    @(negedge clk_i);
    chk("R10 result held", result_o, held);
    chk("R10 no strobe", {31'd0, result_we_o}, 32'd0);
    chk("R10 flags held", flags(), fl_hold);
    chk("R10 cs held", {29'd0, cs_o}, 32'd2);

    // R1: reset after activity
    #1 rst_ni = 1'b0;
    #1;
    chk("R1 mid reset flags", flags(), 32'd0);
    chk("R1 mid reset cs/res", {cs_o, result_o[28:0]}, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule